// File: doc/BRIEF.md
# First-Order Multibit Sigma-Delta Modulator

This block is a digital first-order error-feedback modulator that drives a coarse multibit DAC, such as a small resistor ladder or a switched reference. A slowly updated unsigned sample is latched into a holding register when the sample strobe is high. A faster modulator tick drives the modulation. On each tick the held sample is added to the residue kept from the previous tick. The high bits of that sum become the new output code, and the low bits are kept as the next residue. Averaged over many ticks, the coarse code therefore tracks the fine input, and the quantization noise is pushed towards high frequencies, where an external low-pass filter removes it.

The sum is `SUM_W` bits wide and the output takes its top `OUT_W` bits, so the residue is `SUM_W-OUT_W` bits. The MSB of the input is forced to zero when the sample is captured, which limits the input to half scale. Because the residue is always smaller than `2^(SUM_W-OUT_W)`, the sum can then never wrap. The same structure works for any `OUT_W` from 1 (a plain on/off output) up to `SUM_W-1`.

Top module: `sdm_mod`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the output code, the residue and the held sample to zero, and the code reads 0 in the cycle after that edge.
- R2: On a clock edge with `sample_stb` high, the held sample becomes `sample_in` with its MSB (bit `SUM_W-1`) forced to 0. For example, an input of 0xFF acts as 0x7F.
- R3: On a clock edge with `tick` high, the sum is S = held + residue. The code becomes S >> (SUM_W-OUT_W), and the residue becomes the low (SUM_W-OUT_W) bits of S. The new code is visible in the following cycle.
- R4: In a cycle where `tick` is low, the output code keeps its value.
- R5: The held sample is reused on every tick until the next strobe. When the strobe and the tick arrive in the same cycle, the tick uses the previously held sample, and the new sample applies from the next tick onward.
- R6: Start from a zero residue and apply a constant held input x for W ticks. Let C be the sum of the W output codes. Then C*2^(SUM_W-OUT_W) lies in the interval (x*W - 2^(SUM_W-OUT_W), x*W].
- R7: With `OUT_W` = 1, the output is a single on/off bit and the averaging of R6 still holds.
- R8: For any held input, the code produced by a tick lies between held >> (SUM_W-OUT_W) and that value plus 1. Because the input is limited to half scale, the sum never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Captures `sample_in` into the holding register |
| sample_in | input | SUM_W | Unsigned input sample; its MSB is ignored |
| tick | input | 1 | Modulator update strobe |
| code_out | output | OUT_W | Coarse code for the DAC |

## Verification
A corrupted residue is not visible in a single code. It shows up as a code that is off by one on the very next tick, or as a running mean that drifts away from the input over the following few ticks. For that reason, every tick result is compared against an independent model of the held value and the residue. A wrong held value shifts every following code at once, which the per-tick range check catches. A code that changes without a tick shows up within one cycle. An overflowing sum would make the code fall below the floor of the held value, so the first saturating tick exposes it.

// File: rtl/sdm_mod.sv
module sdm_mod #(
  parameter int SUM_W = 8,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_stb,
  input  logic [SUM_W-1:0] sample_in,
  input  logic             tick,
  output logic [OUT_W-1:0] code_out
);
  localparam int RES_W = SUM_W - OUT_W;
  localparam logic [SUM_W-1:0] HALF_MASK = {1'b0, {(SUM_W-1){1'b1}}};

  logic [SUM_W-1:0] hold;
  logic [RES_W-1:0] residue;
  logic [SUM_W-1:0] sum;

  assign sum = hold + {{OUT_W{1'b0}}, residue};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      residue  <= '0;
      code_out <= '0;
    end else begin
      if (tick) begin
        code_out <= sum[SUM_W-1:RES_W];
        residue  <= sum[RES_W-1:0];
      end
      if (sample_stb) hold <= sample_in & HALF_MASK;
    end
  end
endmodule

// File: rtl/sdm_mod_chk.sv
module sdm_mod_chk #(
  parameter int SUM_W = 8,
  parameter int OUT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_stb,
  input logic             tick,
  input logic [SUM_W-1:0] hold,
  input logic [OUT_W-1:0] code_out
);
  localparam int RES_W = SUM_W - OUT_W;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> code_out == '0); // R1
  AST_MSB_ZERO: assert property (@(posedge clk) disable iff (rst) sample_stb |=> !hold[SUM_W-1]); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(code_out)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    tick |=> ({{RES_W{1'b0}}, code_out} >= ($past(hold) >> RES_W)) &&
             ({{RES_W{1'b0}}, code_out} <= ($past(hold) >> RES_W) + 1'b1)); // R8
endmodule

bind sdm_mod sdm_mod_chk #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .sample_stb(sample_stb), .tick(tick),
  .hold(hold), .code_out(code_out)
);

// File: tb/sim_sdm_mod.sv
module sim_sdm_mod;
  localparam int SUM_W = 8;
  localparam int OUT_W = 4;
  localparam int RES_W = SUM_W - OUT_W;

  typedef struct { int exp; string tag; } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_stb = 1'b0;
  logic [SUM_W-1:0] sample_in = '0;
  logic tick = 1'b0;
  logic [OUT_W-1:0] code0;
  logic code1;

  int nchk = 0, nerr = 0;
  item_t sb[$];
  int m_hold = 0, m_res = 0, last_exp = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdm_mod #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u0 (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .sample_in(sample_in),
    .tick(tick), .code_out(code0));

  sdm_mod #(.SUM_W(SUM_W), .OUT_W(1)) u1 (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .sample_in(sample_in),
    .tick(tick), .code_out(code1));

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle; obs0/obs1 are the outputs seen at this negedge
  task automatic step(bit stb, int val, bit tk, string tag, output int obs0, output int obs1);
    item_t it;
    @(negedge clk);
    obs0 = int'(code0);
    obs1 = int'(code1);
    sample_stb = stb;
    sample_in  = val[SUM_W-1:0];
    tick       = tk;
    if (tk) begin
      it.exp = (m_hold + m_res) >> RES_W;
      it.tag = tag;
      m_res  = (m_hold + m_res) % (1 << RES_W);
      sb.push_back(it);
    end
    if (stb) m_hold = val % (1 << (SUM_W - 1));
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    bit t, r;
    item_t it;
    t = tick;
    r = rst;
    #2;
    if (r) last_exp = 0;
    else if (t) begin
      if (sb.size() == 0) check("R3 (empty queue)", 1, 0);
      else begin
        it = sb.pop_front();
        check(it.tag, int'(code0), it.exp);
        last_exp = it.exp;
      end
    end else if (!done) check("R4", int'(code0), last_exp);
  end

  initial begin
    #2_000_000;
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    int o0, o1, acc0, acc1, x;
    repeat (3) @(negedge clk);
    check("R1 reset code u0", int'(code0), 0);
    check("R1 reset code u1", int'(code1), 0);
    rst = 1'b0;

    // R6 / R7: constant input mean from zero residue
    x = 8'h35;
    step(1, x, 0, "R3", o0, o1);
    acc0 = 0; acc1 = 0;
    for (int i = 0; i <= 128; i++) begin
      step(0, 0, i < 128, "R3", o0, o1);
      if (i > 0) begin acc0 += o0; acc1 += o1; end
    end
    nchk++;
    if (!(acc0 * 16 <= x * 128 && acc0 * 16 > x * 128 - 16)) begin
      nerr++;
      $display("FAIL R6: actual %0d expected in (%0d,%0d]", acc0 * 16, x * 128 - 16, x * 128);
    end
    nchk++;
    if (!(acc1 * 128 <= x * 128 && acc1 * 128 > x * 128 - 128)) begin
      nerr++;
      $display("FAIL R7: actual %0d expected in (%0d,%0d]", acc1 * 128, x * 128 - 128, x * 128);
    end

    // R2: full-scale input treated as half scale
    step(1, 8'hFF, 0, "R2", o0, o1);
    for (int i = 0; i < 20; i++) step(0, 0, 1, "R2", o0, o1);

    // R4: idle gap
    for (int i = 0; i < 6; i++) step(0, 0, 0, "R4", o0, o1);

    // R5: strobe and tick in the same cycle
    step(1, 8'h10, 1, "R5", o0, o1);
    step(0, 0, 1, "R5", o0, o1);
    step(1, 8'h70, 1, "R5", o0, o1);
    for (int i = 0; i < 4; i++) step(0, 0, 1, "R5", o0, o1);

    // zero input flushes to zero codes
    step(1, 0, 0, "R3", o0, o1);
    for (int i = 0; i < 20; i++) step(0, 0, 1, "R3", o0, o1);

    // R3/R8: sine stimulus, about 8 ticks per sample
    for (int s = 0; s < 128; s++) begin
      int v;
      v = 64 + $rtoi(63.0 * $sin(2.0 * 3.14159265358979 * s / 128.0));
      step(1, v, 1, "R8", o0, o1);
      for (int k = 0; k < 7; k++) step(0, 0, 1, "R3", o0, o1);
    end

    // R1: reset mid-run clears residue; next code from clean state
    step(0, 0, 0, "R1", o0, o1);
    rst = 1'b1;
    step(0, 0, 0, "R1", o0, o1);
    m_hold = 0; m_res = 0;
    rst = 1'b0;
    step(0, 0, 0, "R1", o0, o1);
    check("R1 code after reset", o0, 0);
    step(1, 8'h0F, 1, "R1", o0, o1);
    step(0, 0, 1, "R1", o0, o1);
    step(0, 0, 0, "R1", o0, o1);
    step(0, 0, 0, "R1", o0, o1);

    done = 1'b1;
    check("R3 queue drained", sb.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule